// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block is the 8-bit status register of one channel in a multi-channel 16-bit timer. It watches the channel counter from outside and detects when the counter wraps. A step from all-ones to zero sets a sticky overflow flag. A step from zero to all-ones sets a sticky underflow flag, but only on the channels that support phase counting and only while that mode is on. On the channel that runs complementary PWM, a step from one to zero also counts as an overflow while that mode is active. The register also shows the count direction the counter reports. Several of its bits have fixed values.

Software reads the register and clears a flag by writing zero to its bit. The write only takes effect if an earlier read returned that flag as one. Each flag keeps a private marker for this. A read that returns one arms the marker, and the next write to the register uses it up. On the PWM channel, a DMA-style transfer controller can also clear the overflow flag when it is triggered by the overflow interrupt. The parameter `CH_IDX` selects which bits are real on a given channel. Two interrupt requests are formed from the flags and their enable inputs.

Top module: `tmr_stat_reg`

## Requirements
- R1: Bit 7 shows the count direction input as it was sampled at the previous clock edge (1 = up, 0 = down). Its reset value is 1. On channel 0 the bit always reads 1.
- R2: Bit 6 and bits 3..0 always read 1, and no write changes them.
- R3: Bit 5 (underflow) sets when the counter goes from 0x0000 to 0xFFFF. This happens only on channels 1 and 2 while phase counting mode is on. On every other channel, or with the mode off, the bit stays 0.
- R4: On every channel, bit 4 (overflow) sets when the counter goes from 0xFFFF to 0x0000.
- R5: On channel 4 with complementary PWM mode on, the overflow flag also sets when the counter goes from 0x0001 to 0x0000. This transition has no effect when the mode is off.
- R6: A flag clears when software writes 0 to its bit and an earlier read returned 1 for that bit. Writing 1 leaves the flag unchanged. A write of 0 with no such earlier read also leaves it unchanged.
- R7: Any register write uses up the read marker of both flags. A read that returns 0 does not arm the marker.
- R8: If a set condition and a clear happen in the same cycle, the flag is 1 afterwards.
- R9: On channel 4, a cycle with the DMA trigger high and the keep input low clears the overflow flag. With keep high, or on any other channel, the trigger has no effect.
- R10: The overflow request equals the overflow flag AND its enable input. The underflow request equals the underflow flag AND its own enable input.
- R11: After reset the register reads 0xCF and both requests are low.
- R12: A flag changes one clock edge after the cycle in which the counter shows the new value. Read data always shows the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val_i | input | CNT_W | Current counter value |
| cnt_up_i | input | 1 | Counter direction, 1 = up |
| phase_mode_i | input | 1 | Phase counting mode active |
| cpwm_mode_i | input | 1 | Complementary PWM mode active |
| rd_en_i | input | 1 | Software read strobe |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Software write data |
| dma_trig_i | input | 1 | Transfer controller triggered by overflow interrupt |
| dma_keep_i | input | 1 | Controller setting that keeps the flag (1 = no clear) |
| ovf_ien_i | input | 1 | Overflow interrupt enable |
| unf_ien_i | input | 1 | Underflow interrupt enable |
| rd_data_o | output | 8 | Register contents |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| unf_irq_o | output | 1 | Underflow interrupt request |

## Verification
The hardest case to reach is a set and a clear in the same cycle. The flag must already be set, a read must have armed its marker, and the counter must sit at 0xFFFF. The clearing write and the step to 0x0000 must then arrive on the same edge. The bench builds this with a scripted sequence of counter values and strobes. It also runs three instances for channels 4, 1 and 0 on shared counter stimulus, so that the same wrap shows a present bit on one channel and a reserved bit on another.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int CNT_W   = 16;
    localparam int REG_W   = 8;
    localparam int DIR_POS = 7;
    localparam int UNF_POS = 5;
    localparam int OVF_POS = 4;
    localparam int NFLAG   = 2;
    localparam int FL_UNF  = 0;
    localparam int FL_OVF  = 1;
    localparam logic [REG_W-1:0] FIXED_ONES = 8'b0100_1111;

    typedef struct packed {
        logic armed;
        logic flag;
    } flag_st_t;
endpackage

// File: rtl/tsr_wrap_detect.sv
module tsr_wrap_detect #(
    parameter int CNT_W  = tsr_pkg::CNT_W,
    parameter int CH_IDX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             phase_i,
    input  logic             cpwm_i,
    output logic             ovf_evt_o,
    output logic             unf_evt_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ZERO     = '0;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam bit UNF_EN  = (CH_IDX == 1) || (CH_IDX == 2);
    localparam bit CPWM_EN = (CH_IDX == 4);

    typedef struct packed {
        logic [CNT_W-1:0] prev;
        logic             valid;
    } wrap_st_t;

    wrap_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = cnt_i;
        st_d.valid = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ovf_evt_o = st_q.valid && (cnt_i == ZERO) &&
                    ((st_q.prev == ALL_ONES) ||
                     (CPWM_EN && cpwm_i && (st_q.prev == ONE)));
        unf_evt_o = st_q.valid && UNF_EN && phase_i &&
                    (st_q.prev == ZERO) && (cnt_i == ALL_ONES);
    end

    // R4 R5
    ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt_o |-> (($past(cnt_i) == ALL_ONES) || ($past(cnt_i) == ONE)));

    // R3
    unf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt_o |-> (phase_i && ($past(cnt_i) == ZERO)));
endmodule

// File: rtl/tsr_flag_cell.sv
module tsr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    import tsr_pkg::*;

    flag_st_t st_d, st_q;
    logic     sw_clr;

    always_comb begin
        st_d   = st_q;
        sw_clr = wr_i && st_q.armed && !wr_bit_i;
        // a set condition overrides any clear in the same cycle
        st_d.flag = set_i || (st_q.flag && !(sw_clr || hw_clr_i));
        if (wr_i) begin
            st_d.armed = 1'b0;
        end else if (rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R6
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(hw_clr_i || (wr_i && !wr_bit_i)));

    // R7
    arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(rd_i && flag_o));
endmodule

// File: rtl/tsr_read_mux.sv
module tsr_read_mux #(
    parameter int CH_IDX = 4
) (
    input  logic                      dir_i,
    input  logic                      unf_i,
    input  logic                      ovf_i,
    output logic [tsr_pkg::REG_W-1:0] rd_data_o
);
    import tsr_pkg::*;

    localparam bit DIR_FIXED = (CH_IDX == 0);

    always_comb begin
        rd_data_o          = FIXED_ONES;
        rd_data_o[DIR_POS] = DIR_FIXED ? 1'b1 : dir_i;
        rd_data_o[UNF_POS] = unf_i;
        rd_data_o[OVF_POS] = ovf_i;
    end
endmodule

// File: rtl/tmr_stat_reg.sv
module tmr_stat_reg #(
    parameter int CH_IDX = 4,
    parameter int CNT_W  = tsr_pkg::CNT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          cnt_val_i,
    input  logic                      cnt_up_i,
    input  logic                      phase_mode_i,
    input  logic                      cpwm_mode_i,
    input  logic                      rd_en_i,
    input  logic                      wr_en_i,
    input  logic [tsr_pkg::REG_W-1:0] wr_data_i,
    input  logic                      dma_trig_i,
    input  logic                      dma_keep_i,
    input  logic                      ovf_ien_i,
    input  logic                      unf_ien_i,
    output logic [tsr_pkg::REG_W-1:0] rd_data_o,
    output logic                      ovf_irq_o,
    output logic                      unf_irq_o
);
    import tsr_pkg::*;

    localparam bit IS_PWM_CH = (CH_IDX == 4);

    typedef struct packed {
        logic dir;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             ovf_evt, unf_evt;
    logic [NFLAG-1:0] fl_set, fl_hwclr, fl_wbit, fl_q;
    logic             unused_wr;

    always_comb begin
        st_d     = st_q;
        st_d.dir = cnt_up_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    tsr_wrap_detect #(
        .CNT_W  (CNT_W),
        .CH_IDX (CH_IDX)
    ) u_wrap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt_val_i),
        .phase_i   (phase_mode_i),
        .cpwm_i    (cpwm_mode_i),
        .ovf_evt_o (ovf_evt),
        .unf_evt_o (unf_evt)
    );

    always_comb begin
        fl_set[FL_UNF]   = unf_evt;
        fl_set[FL_OVF]   = ovf_evt;
        fl_hwclr[FL_UNF] = 1'b0;
        fl_hwclr[FL_OVF] = IS_PWM_CH && dma_trig_i && !dma_keep_i;
        fl_wbit[FL_UNF]  = wr_data_i[UNF_POS];
        fl_wbit[FL_OVF]  = wr_data_i[OVF_POS];
    end

    assign unused_wr = ^{wr_data_i[7:6], wr_data_i[3:0]};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        tsr_flag_cell u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (fl_set[g]),
            .hw_clr_i (fl_hwclr[g]),
            .rd_i     (rd_en_i),
            .wr_i     (wr_en_i),
            .wr_bit_i (fl_wbit[g]),
            .flag_o   (fl_q[g])
        );
    end

    tsr_read_mux #(
        .CH_IDX (CH_IDX)
    ) u_rdmux (
        .dir_i     (st_q.dir),
        .unf_i     (fl_q[FL_UNF]),
        .ovf_i     (fl_q[FL_OVF]),
        .rd_data_o (rd_data_o)
    );

    assign ovf_irq_o = fl_q[FL_OVF] && ovf_ien_i;
    assign unf_irq_o = fl_q[FL_UNF] && unf_ien_i;

    // R10
    ovf_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq_o |-> (ovf_ien_i && rd_data_o[OVF_POS]));

    // R10
    unf_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_irq_o |-> (unf_ien_i && rd_data_o[UNF_POS]));

    // R9
    dma_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_trig_i && !dma_keep_i && IS_PWM_CH && !ovf_evt) |=> !rd_data_o[OVF_POS]);
endmodule

// File: tb/tmr_stat_reg_tb.sv
module tmr_stat_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NDUT = 3;   // 0: channel 4, 1: channel 1, 2: channel 0

    typedef struct packed {
        logic [15:0] cnt;
        logic        cpwm;
        logic        clr;
        logic        exp_ovf;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{16'hFFFF, 1'b0, 1'b0, 1'b0},
        '{16'h0000, 1'b0, 1'b0, 1'b1},
        '{16'h0005, 1'b0, 1'b1, 1'b0},
        '{16'h0001, 1'b1, 1'b0, 1'b0},
        '{16'h0000, 1'b1, 1'b0, 1'b1},
        '{16'h0001, 1'b0, 1'b1, 1'b0},
        '{16'h0000, 1'b0, 1'b0, 1'b0},
        '{16'hFFFF, 1'b0, 1'b0, 1'b0},
        '{16'h0000, 1'b0, 1'b0, 1'b1},
        '{16'h0002, 1'b0, 1'b1, 1'b0},
        '{16'h0000, 1'b1, 1'b0, 1'b0},
        '{16'hFFFF, 1'b1, 1'b0, 1'b0},
        '{16'h0000, 1'b1, 1'b0, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [15:0]     cnt;
    logic            cnt_up, phase, cpwm, dma_trig, dma_keep, ovf_ien, unf_ien;
    logic [7:0]      wr_data;
    logic [NDUT-1:0] rd_en, wr_en, ovf_irq, unf_irq;
    logic [7:0]      rd_data [NDUT];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_stat_reg #(.CH_IDX(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val_i(cnt), .cnt_up_i(cnt_up),
        .phase_mode_i(phase), .cpwm_mode_i(cpwm), .rd_en_i(rd_en[0]),
        .wr_en_i(wr_en[0]), .wr_data_i(wr_data), .dma_trig_i(dma_trig),
        .dma_keep_i(dma_keep), .ovf_ien_i(ovf_ien), .unf_ien_i(unf_ien),
        .rd_data_o(rd_data[0]), .ovf_irq_o(ovf_irq[0]), .unf_irq_o(unf_irq[0])
    );

    tmr_stat_reg #(.CH_IDX(1)) u_dut_c1 (
        .clk(clk), .rst_n(rst_n), .cnt_val_i(cnt), .cnt_up_i(cnt_up),
        .phase_mode_i(phase), .cpwm_mode_i(cpwm), .rd_en_i(rd_en[1]),
        .wr_en_i(wr_en[1]), .wr_data_i(wr_data), .dma_trig_i(dma_trig),
        .dma_keep_i(dma_keep), .ovf_ien_i(ovf_ien), .unf_ien_i(unf_ien),
        .rd_data_o(rd_data[1]), .ovf_irq_o(ovf_irq[1]), .unf_irq_o(unf_irq[1])
    );

    tmr_stat_reg #(.CH_IDX(0)) u_dut_c0 (
        .clk(clk), .rst_n(rst_n), .cnt_val_i(cnt), .cnt_up_i(cnt_up),
        .phase_mode_i(phase), .cpwm_mode_i(cpwm), .rd_en_i(rd_en[2]),
        .wr_en_i(wr_en[2]), .wr_data_i(wr_data), .dma_trig_i(dma_trig),
        .dma_keep_i(dma_keep), .ovf_ien_i(ovf_ien), .unf_ien_i(unf_ien),
        .rd_data_o(rd_data[2]), .ovf_irq_o(ovf_irq[2]), .unf_irq_o(unf_irq[2])
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic clear_flags(input int idx);
        rd_en[idx] = 1'b1;
        tick();
        rd_en[idx] = 1'b0;
        wr_en[idx] = 1'b1;
        wr_data    = 8'h00;
        tick();
        wr_en[idx] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cnt = 16'h1234; cnt_up = 1'b1; phase = 1'b0; cpwm = 1'b0;
        dma_trig = 1'b0; dma_keep = 1'b0; ovf_ien = 1'b0; unf_ien = 1'b0;
        wr_data = 8'h00; rd_en = '0; wr_en = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R11 reset state
        chk("R11 ch4 reset", rd_data[0], 8'hCF);
        chk("R11 ch1 reset", rd_data[1], 8'hCF);
        chk("R11 ch0 reset", rd_data[2], 8'hCF);
        chk("R11 irq reset", {2'b0, ovf_irq, unf_irq}, 8'h00);

        // R4 R5 R12 vector walk on channel 4
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].clr) clear_flags(0);
            cnt  = VECS[i].cnt;
            cpwm = VECS[i].cpwm;
            tick();
            chk($sformatf("R4 R5 R12 vector %0d", i), {7'b0, rd_data[0][4]}, {7'b0, VECS[i].exp_ovf});
        end
        cpwm = 1'b0;

        // R10 overflow request gating (ch4 overflow flag is 1)
        ovf_ien = 1'b1;
        tick();
        chk("R10 ovf irq enabled", {7'b0, ovf_irq[0]}, 8'h01);
        ovf_ien = 1'b0;
        tick();
        chk("R10 ovf irq disabled", {7'b0, ovf_irq[0]}, 8'h00);

        // R9 transfer-controller clear
        dma_trig = 1'b1; dma_keep = 1'b1;
        tick();
        dma_trig = 1'b0;
        chk("R9 keep set, no clear", {7'b0, rd_data[0][4]}, 8'h01);
        dma_trig = 1'b1; dma_keep = 1'b0;
        tick();
        dma_trig = 1'b0;
        chk("R9 ch4 cleared", {7'b0, rd_data[0][4]}, 8'h00);
        chk("R9 ch1 unaffected", {7'b0, rd_data[1][4]}, 8'h01);

        // R3 underflow in phase counting mode
        clear_flags(1);
        phase = 1'b1; unf_ien = 1'b1;
        cnt = 16'hFFFF;
        tick();
        chk("R3 ch1 underflow set", {7'b0, rd_data[1][5]}, 8'h01);
        chk("R3 ch4 bit reserved", {7'b0, rd_data[0][5]}, 8'h00);
        chk("R3 ch0 bit reserved", {7'b0, rd_data[2][5]}, 8'h00);
        chk("R10 unf irq ch1", {7'b0, unf_irq[1]}, 8'h01);
        chk("R10 unf irq ch4", {7'b0, unf_irq[0]}, 8'h00);
        phase = 1'b0; unf_ien = 1'b0;
        clear_flags(1);
        chk("R6 underflow cleared", {7'b0, rd_data[1][5]}, 8'h00);
        cnt = 16'h0000;
        tick();
        cnt = 16'hFFFF;
        tick();
        chk("R3 mode off no underflow", {7'b0, rd_data[1][5]}, 8'h00);

        // R6 clear rules on channel 1 (overflow flag is 1)
        wr_en[1] = 1'b1; wr_data = 8'h00;
        tick();
        wr_en[1] = 1'b0;
        chk("R6 write 0 without read", {7'b0, rd_data[1][4]}, 8'h01);
        rd_en[1] = 1'b1;
        tick();
        rd_en[1] = 1'b0;
        wr_en[1] = 1'b1; wr_data = 8'h10;
        tick();
        wr_en[1] = 1'b0;
        chk("R6 write 1 no effect", {7'b0, rd_data[1][4]}, 8'h01);
        wr_en[1] = 1'b1; wr_data = 8'h00;
        tick();
        wr_en[1] = 1'b0;
        chk("R7 marker consumed", {7'b0, rd_data[1][4]}, 8'h01);
        clear_flags(1);
        chk("R6 read then write 0 clears", {7'b0, rd_data[1][4]}, 8'h00);

        // R7 a read of 0 does not arm
        rd_en[1] = 1'b1;
        tick();
        rd_en[1] = 1'b0;
        cnt = 16'h0000;
        tick();
        chk("R4 ch1 overflow set", {7'b0, rd_data[1][4]}, 8'h01);
        wr_en[1] = 1'b1; wr_data = 8'h00;
        tick();
        wr_en[1] = 1'b0;
        chk("R7 zero read not armed", {7'b0, rd_data[1][4]}, 8'h01);

        // R8 set wins over clear on channel 4
        clear_flags(0);
        cnt = 16'hFFFF;
        tick();
        cnt = 16'h0000;
        tick();
        cnt = 16'hFFFF;
        tick();
        rd_en[0] = 1'b1;
        tick();
        rd_en[0] = 1'b0;
        wr_en[0] = 1'b1; wr_data = 8'h00; cnt = 16'h0000;
        tick();
        wr_en[0] = 1'b0;
        chk("R8 set beats clear", {7'b0, rd_data[0][4]}, 8'h01);
        clear_flags(0);
        chk("R6 ch4 cleared after", {7'b0, rd_data[0][4]}, 8'h00);

        // R1 direction bit
        cnt_up = 1'b0;
        tick();
        chk("R1 ch4 down", rd_data[0], 8'h4F);
        chk("R1 ch0 fixed", {7'b0, rd_data[2][7]}, 8'h01);
        cnt_up = 1'b1;
        tick();
        chk("R1 ch4 up", {7'b0, rd_data[0][7]}, 8'h01);

        // R2 fixed bits ignore writes
        wr_en[2] = 1'b1; wr_data = 8'h00;
        wr_en[1] = 1'b1;
        tick();
        wr_en = '0;
        chk("R2 ch0 after write 0", rd_data[2] & 8'hCF, 8'hCF);
        wr_en[1] = 1'b1; wr_data = 8'hFF;
        tick();
        wr_en = '0;
        chk("R2 ch1 after write FF", rd_data[1] & 8'h4F, 8'h4F);

        finish_run();
    end
endmodule